// File: doc/BRIEF.md
# Host Write Port with Acknowledge Flow Control

This block is the receiving end of a host write port. An external host places 16-bit words into an on-chip FIFO through an asynchronous strobe interface made of a chip select, an address, a write strobe and a data bus. All of the strobe-side inputs go through a two-flop synchronizer into the system clock domain. A write completes when the synchronized write strobe returns high while chip select is active. At that point the last data and address values sampled while the strobe was low are pushed into the FIFO as one entry. On-chip logic drains the FIFO through a valid/ready output stream.

The port has two flow-control modes, chosen by `ack_mode`.

In acknowledge mode (`ack_mode` = 1), `host_rdy` goes low a few clock cycles after chip select is seen. It goes high again only once the FIFO has room for the word. The host must hold its strobe low until `host_rdy` has returned high.

In timed mode (`ack_mode` = 0), `host_rdy` stays high. The host instead keeps to a minimum strobe low time and a minimum idle time between strobes. A timed-mode write that finds the FIFO full is discarded, and a sticky `overflow` flag is set.

On the output stream, a word is transferred on every clock edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the head word stays on `rd_addr`/`rd_data` without change. `rd_valid` is high exactly when the FIFO holds at least one word.

Top module: `host_wr_port`

## Requirements
- R1: After reset, `host_rdy` is 1, `rd_valid` is 0 and `overflow` is 0.
- R2: A write strobe (`host_we_n` low, then high) with `host_cs_n` low throughout puts the pair {`host_addr`, `host_data`} into the FIFO. `rd_valid` rises no later than the fifth clock edge after the strobe rises.
- R3: A write strobe given while `host_cs_n` is high leaves the FIFO unchanged, so `rd_valid` stays 0.
- R4: Words leave the FIFO in the order they were written. A word is removed only on an edge where `rd_valid` and `rd_ready` are both 1. While `rd_valid` is 1 and `rd_ready` is 0, `rd_addr` and `rd_data` hold steady.
- R5: In acknowledge mode, with room in the FIFO, `host_rdy` goes low after `host_cs_n` falls and then returns to 1 without any read taking place.
- R6: In acknowledge mode, with the FIFO full (DEPTH words), `host_rdy` stays 0 while chip select is held. It returns to 1 only after a word has been read. The pending write then lands in the FIFO behind the words already there.
- R7: In timed mode, `host_rdy` stays 1 at all times, including during a write.
- R8: In timed mode, a write that finds the FIFO full is discarded and `overflow` becomes 1. `overflow` stays 1 until reset, even after later writes succeed.
- R9: The stored data is the last value seen on `host_data` while the strobe was low. A change on `host_data` one clock after the strobe rises has no effect on the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_mode | input | 1 | 1 = acknowledge flow control, 0 = timed mode |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_addr | input | ADDR_W | Host address, asynchronous |
| host_we_n | input | 1 | Host write strobe, active low, asynchronous |
| host_data | input | 16 | Host write data, asynchronous |
| host_rdy | output | 1 | Acknowledge to host; low means the host must hold the strobe |
| rd_valid | output | 1 | FIFO head word is present |
| rd_ready | input | 1 | Consumer accepts the head word |
| rd_addr | output | ADDR_W | Address stored with the head word |
| rd_data | output | 16 | Head data word |
| overflow | output | 1 | Sticky: a timed-mode write was dropped |

## Verification
The hardest state to reach from the ports is an acknowledge-mode write that stalls against a full FIFO. The host has to keep both chip select and strobe low while `host_rdy` stays low, and the read side has to free an entry in the middle of that pending access. The bench first fills the FIFO with acknowledged writes while holding `rd_ready` low. It then opens a fifth access and lets the acknowledge stay low for many cycles. Next it pops one word and waits for `host_rdy` to rise before releasing the strobe. Finally it drains the FIFO to confirm that the stalled word came out last.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  localparam int HOST_DW = 16;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_WAIT  = 2'd1,
    HS_GRANT = 2'd2
  } hs_state_t;
endpackage

// File: rtl/hwp_sync.sv
module hwp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hwp_fifo.sv
module hwp_fifo #(
  parameter int DW    = 18,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_word,
  output logic          full,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_word
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wr_ptr, rd_ptr, count;
  logic          pop;

  assign count     = wr_ptr - rd_ptr;
  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready;
  assign out_word  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push && !full) wr_ptr <= wr_ptr + 1'b1;
      if (pop)           rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr[AW-1:0]] <= push_word;
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r4_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));
endmodule

// File: rtl/hwp_front.sv
module hwp_front
  import hwp_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ack_mode,
  input  logic                            cs_n_s,
  input  logic                            we_n_s,
  input  logic [ADDR_W-1:0]               addr_s,
  input  logic [HOST_DW-1:0]              data_s,
  input  logic                            fifo_full,
  output logic                            push,
  output logic [ADDR_W+HOST_DW-1:0]       push_word,
  output logic                            host_rdy,
  output logic                            overflow
);
  hs_state_t           st, st_nx;
  logic                we_q;
  logic                commit;
  logic [ADDR_W-1:0]   hold_addr;
  logic [HOST_DW-1:0]  hold_data;

  // end of strobe: synchronized strobe returns high under chip select
  assign commit    = !we_q && we_n_s && !cs_n_s;
  assign push      = commit && !fifo_full;
  assign push_word = {hold_addr, hold_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      hold_addr <= '0;
      hold_data <= '0;
      overflow  <= 1'b0;
    end else begin
      we_q <= we_n_s;
      if (!we_n_s) begin
        hold_addr <= addr_s;
        hold_data <= data_s;
      end
      if (commit && fifo_full) overflow <= 1'b1;
    end
  end

  always_comb begin
    st_nx = st;
    if (!ack_mode) begin
      st_nx = HS_IDLE;
    end else begin
      unique case (st)
        HS_IDLE:  if (!cs_n_s) st_nx = HS_WAIT;
        HS_WAIT:  if (cs_n_s) st_nx = HS_IDLE;
                  else if (!fifo_full) st_nx = HS_GRANT;
        HS_GRANT: if (cs_n_s) st_nx = HS_IDLE;
                  else if (commit) st_nx = HS_WAIT;
        default:  st_nx = HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= HS_IDLE;
    else        st <= st_nx;
  end

  assign host_rdy = (st != HS_WAIT);

  a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_mode && !cs_n_s && st == HS_IDLE |=> !host_rdy);

  a_r6_grant_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdy ##1 host_rdy && ack_mode && !cs_n_s |-> $past(!fifo_full));

  a_r7_timed_rdy_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_mode |=> host_rdy);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/host_wr_port.sv
module host_wr_port
  import hwp_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_mode,
  input  logic               host_cs_n,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               host_we_n,
  input  logic [15:0]        host_data,
  output logic               host_rdy,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic [15:0]        rd_data,
  output logic               overflow
);
  localparam int WW = ADDR_W + HOST_DW;
  localparam int SW = 2 + WW;
  localparam logic [SW-1:0] SYNC_RST = {2'b11, {WW{1'b0}}};

  logic [SW-1:0] raw_bus, sync_bus;
  logic          cs_n_s, we_n_s;
  logic [ADDR_W-1:0]  addr_s;
  logic [HOST_DW-1:0] data_s;
  logic          fifo_full, push;
  logic [WW-1:0] push_word, head_word;

  assign raw_bus = {host_cs_n, host_we_n, host_addr, host_data};

  hwp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign {cs_n_s, we_n_s, addr_s, data_s} = sync_bus;

  hwp_front #(.ADDR_W(ADDR_W)) u_front (
    .clk(clk), .rst_n(rst_n), .ack_mode(ack_mode),
    .cs_n_s(cs_n_s), .we_n_s(we_n_s), .addr_s(addr_s), .data_s(data_s),
    .fifo_full(fifo_full), .push(push), .push_word(push_word),
    .host_rdy(host_rdy), .overflow(overflow)
  );

  hwp_fifo #(.DW(WW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word),
    .full(fifo_full), .out_valid(rd_valid), .out_ready(rd_ready),
    .out_word(head_word)
  );

  assign {rd_addr, rd_data} = head_word;
endmodule

// File: tb/tb_host_wr_port.sv
module tb_host_wr_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ack_mode = 1'b0;
  logic host_cs_n = 1'b1, host_we_n = 1'b1;
  logic [1:0] host_addr = '0;
  logic [15:0] host_data = '0;
  logic rd_ready = 1'b0;
  logic host_rdy, rd_valid, overflow;
  logic [1:0] rd_addr;
  logic [15:0] rd_data;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  host_wr_port dut (
    .clk(clk), .rst_n(rst_n), .ack_mode(ack_mode),
    .host_cs_n(host_cs_n), .host_addr(host_addr), .host_we_n(host_we_n),
    .host_data(host_data), .host_rdy(host_rdy), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .overflow(overflow)
  );

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0; ack_mode = mode; host_cs_n = 1'b1; host_we_n = 1'b1; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one host write; in ack mode waits for host_rdy low then high before release
  task automatic host_write(input logic [1:0] a, input logic [15:0] d, input bit ack,
                            input bit mid, input logic [15:0] d2);
    bit saw_low = 0, saw_high = 0;
    @(negedge clk);
    host_cs_n = 1'b0; host_addr = a; host_data = d;
    @(negedge clk);
    host_we_n = 1'b0;
    if (mid) begin @(negedge clk); host_data = d2; end
    if (ack) begin
      for (int i = 0; i < 40 && !saw_low; i++) begin @(negedge clk); if (!host_rdy) saw_low = 1; end
      for (int i = 0; i < 40 && !saw_high; i++) begin @(negedge clk); if (host_rdy) saw_high = 1; end
      chk(saw_low, "R5 rdy low", {31'b0, saw_low}, 1);
      chk(saw_high, "R5 rdy high", {31'b0, saw_high}, 1);
    end else begin
      @(negedge clk);
      chk(host_rdy == 1'b1, "R7 rdy in timed write", {31'b0, host_rdy}, 1);
    end
    repeat (3) @(negedge clk);
    host_we_n = 1'b1;
    @(negedge clk);
    host_cs_n = 1'b1; host_data = 16'hDEAD; host_addr = ~a;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_expect(input logic [1:0] a, input logic [15:0] d, input string req);
    for (int i = 0; i < 20 && !rd_valid; i++) @(negedge clk);
    chk(rd_valid, req, {31'b0, rd_valid}, 1);
    chk(rd_data == d && rd_addr == a, req, {14'b0, rd_addr, rd_data}, {14'b0, a, d});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk(host_rdy == 1'b1 && rd_valid == 1'b0 && overflow == 1'b0, "R1 reset",
        {29'b0, host_rdy, rd_valid, overflow}, 32'b100);
  endtask

  task automatic t_timed_basic();
    do_reset(1'b0);
    @(negedge clk);
    host_cs_n = 1'b0; host_addr = 2'd1; host_data = 16'h1234;
    @(negedge clk); host_we_n = 1'b0;
    repeat (4) @(negedge clk); host_we_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rd_valid == 1'b1, "R2 valid by fifth edge", {31'b0, rd_valid}, 1);
    host_cs_n = 1'b1;
    repeat (3) @(negedge clk);
    host_write(2'd2, 16'hAAAA, 1'b0, 1'b1, 16'hBBBB);
    host_write(2'd3, 16'h5555, 1'b0, 1'b0, 16'h0);
    // R4 back-pressure: head held while not ready
    repeat (4) @(negedge clk);
    chk(rd_valid && rd_data == 16'h1234 && rd_addr == 2'd1, "R4 head held",
        {14'b0, rd_addr, rd_data}, {14'b0, 2'd1, 16'h1234});
    pop_expect(2'd1, 16'h1234, "R2 first word");
    pop_expect(2'd2, 16'hBBBB, "R9 last value while low");
    pop_expect(2'd3, 16'h5555, "R4 order");
    @(negedge clk);
    chk(rd_valid == 1'b0, "R4 empty after drain", {31'b0, rd_valid}, 0);
  endtask

  task automatic t_no_cs();
    do_reset(1'b0);
    @(negedge clk); host_data = 16'h7777;
    @(negedge clk); host_we_n = 1'b0;
    repeat (4) @(negedge clk); host_we_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(rd_valid == 1'b0, "R3 no chip select", {31'b0, rd_valid}, 0);
  endtask

  task automatic t_timed_overflow();
    do_reset(1'b0);
    for (int k = 0; k < 4; k++) host_write(k[1:0], 16'h100 + k[15:0], 1'b0, 1'b0, 16'h0);
    chk(overflow == 1'b0, "R8 no overflow before full", {31'b0, overflow}, 0);
    host_write(2'd0, 16'hF00D, 1'b0, 1'b0, 16'h0);
    chk(overflow == 1'b1, "R8 overflow set", {31'b0, overflow}, 1);
    for (int k = 0; k < 4; k++) pop_expect(k[1:0], 16'h100 + k[15:0], "R8 contents kept");
    @(negedge clk);
    chk(rd_valid == 1'b0, "R8 dropped word absent", {31'b0, rd_valid}, 0);
    host_write(2'd1, 16'h4242, 1'b0, 1'b0, 16'h0);
    chk(overflow == 1'b1, "R8 sticky", {31'b0, overflow}, 1);
    pop_expect(2'd1, 16'h4242, "R8 later write");
  endtask

  task automatic t_ack_space();
    do_reset(1'b1);
    host_write(2'd2, 16'hC0DE, 1'b1, 1'b0, 16'h0);
    pop_expect(2'd2, 16'hC0DE, "R5 ack write stored");
  endtask

  task automatic t_ack_full();
    bit risen = 0;
    do_reset(1'b1);
    for (int k = 0; k < 4; k++) host_write(k[1:0], 16'h200 + k[15:0], 1'b1, 1'b0, 16'h0);
    @(negedge clk);
    host_cs_n = 1'b0; host_addr = 2'd3; host_data = 16'hBEEF;
    @(negedge clk); host_we_n = 1'b0;
    repeat (15) @(negedge clk);
    chk(host_rdy == 1'b0, "R6 rdy held low while full", {31'b0, host_rdy}, 0);
    pop_expect(2'd0, 16'h200, "R6 first out");
    for (int i = 0; i < 20 && !risen; i++) begin @(negedge clk); if (host_rdy) risen = 1; end
    chk(risen, "R6 rdy rises after read", {31'b0, risen}, 1);
    repeat (2) @(negedge clk); host_we_n = 1'b1;
    @(negedge clk); host_cs_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int k = 1; k < 4; k++) pop_expect(k[1:0], 16'h200 + k[15:0], "R6 order kept");
    pop_expect(2'd3, 16'hBEEF, "R6 stalled word last");
    chk(overflow == 1'b0, "R6 no drop in ack mode", {31'b0, overflow}, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    t_reset();
    t_timed_basic();
    t_no_cs();
    t_timed_overflow();
    t_ack_space();
    t_ack_full();
    repeat (4) @(negedge clk);
    report();
  end
endmodule